// File: doc/BRIEF.md
# Soft Reset Handshake Sequencer

This block puts an attached processing engine into soft reset in an orderly way. Software writes a control word to a single register port. A write carrying the abort bit starts the sequence. The sequencer raises an abort request towards the engine and waits for the engine to acknowledge it. It then passes through a short assert phase and drives soft reset. Reset is held for a fixed number of cycles, after which the sequencer releases it and returns to idle, ready for the next request.

Software can also write a force bit while the request is pending. This skips the wait for the acknowledge and moves straight to the assert phase, which helps when the engine is hung and will never answer. A status word brings out the current phase. It also shows whether reset is being driven and whether reset was reached through a genuine acknowledge rather than through the force path.

Top module: `srst_handshake`

## Requirements
- R1: After reset the status word reads 0, and abort_req_o and srst_o are both low.
- R2: A write with bit 0 set while the phase is idle (0) moves the phase to requested (1) one cycle later. abort_req_o is high exactly while the phase is requested.
- R3: A write with bit 0 set while the phase is not idle has no effect on the phase.
- R4: In the requested phase, a high eng_ack with no force write moves the phase to acknowledged (2). The acknowledged phase always goes to assert (3) on the next cycle, and assert always goes to set (4) on the next cycle.
- R5: A write with bit 2 set in the requested phase moves the phase straight to assert (3), even if eng_ack is high in the same cycle. A write with bit 2 set in any other phase is ignored.
- R6: srst_o is high exactly while the phase is assert (3) or set (4). Status bit 3 always equals srst_o.
- R7: Status bit 1 reads 1 only while srst_o is high and the sequence went through the acknowledged phase. It reads 0 when reset was reached by a force write.
- R8: The set phase lasts exactly HOLD_CYC cycles (16 by default). The phase then returns to idle and srst_o falls.
- R9: The status word carries the phase in bits 6:4. Bits 0 and 2, and every bit above 6, always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | DATA_W | Write data: bit 0 abort request, bit 2 force |
| eng_ack | input | 1 | Engine acknowledge of the abort request |
| abort_req_o | output | 1 | Abort request to the engine |
| srst_o | output | 1 | Soft reset to the engine |
| status_o | output | DATA_W | Status readback: phase, reset flag, acknowledged flag |

## Verification
The bench aims at the force write and the acknowledge arriving in the same cycle. A design that gave the acknowledge priority would show phase 2 and a set acknowledged flag where phase 3 with a clear flag is expected. It also sends request writes during a busy sequence and force writes while idle. A design that honoured either would restart or jump the sequence. The length of the set phase is counted cycle by cycle, so an off-by-one hold counter shows up as a release one cycle early or late. Random write and acknowledge traffic also checks that the acknowledged flag is cleared at the start of each new request, so that it does not carry over from an earlier run.

// File: rtl/srst_hs_pkg.sv
package srst_hs_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_REQ    = 3'd1,
      PH_ACKED  = 3'd2,
      PH_ASSERT = 3'd3,
      PH_SET    = 3'd4
   } srst_phase_e;

   // control word bit positions
   localparam int unsigned CTL_ABORT_BIT = 0;
   localparam int unsigned CTL_FORCE_BIT = 2;

   // status word bit positions
   localparam int unsigned STS_ACKED_BIT = 1;
   localparam int unsigned STS_SRST_BIT  = 3;
   localparam int unsigned STS_PH_LSB    = 4;
   localparam int unsigned STS_PH_W      = 3;
   localparam int unsigned STS_MIN_W     = STS_PH_LSB + STS_PH_W;

endpackage

// File: rtl/srst_hs_timer.sv
module srst_hs_timer #(
   parameter int unsigned HOLD_CYC = 16,
   localparam int unsigned CNT_W   = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic done_o
);

   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(HOLD_CYC - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= LOAD_VAL;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done_o = (cnt_q == '0);

endmodule

// File: rtl/srst_hs_fsm.sv
module srst_hs_fsm
   import srst_hs_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        abort_wr_i,
   input  logic        force_wr_i,
   input  logic        eng_ack_i,
   input  logic        hold_done_i,
   output srst_phase_e phase_o,
   output logic        hold_load_o,
   output logic        srst_o,
   output logic        acked_o
);

   srst_phase_e phase_q, phase_d;
   logic        srst_q;
   logic        acked_q, acked_d;

   always_comb begin
      phase_d = phase_q;
      acked_d = acked_q;
      unique case (phase_q)
         PH_IDLE: begin
            if (abort_wr_i) begin
               phase_d = PH_REQ;
               acked_d = 1'b0;
            end
         end
         PH_REQ: begin
            if (force_wr_i) begin
               phase_d = PH_ASSERT;
            end else if (eng_ack_i) begin
               phase_d = PH_ACKED;
               acked_d = 1'b1;
            end
         end
         PH_ACKED:  phase_d = PH_ASSERT;
         PH_ASSERT: phase_d = PH_SET;
         PH_SET: begin
            if (hold_done_i) begin
               phase_d = PH_IDLE;
               acked_d = 1'b0;
            end
         end
         default: begin
            phase_d = PH_IDLE;
            acked_d = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         srst_q  <= 1'b0;
         acked_q <= 1'b0;
      end else begin
         phase_q <= phase_d;
         srst_q  <= (phase_d == PH_ASSERT) || (phase_d == PH_SET);
         acked_q <= acked_d;
      end
   end

   assign phase_o     = phase_q;
   assign hold_load_o = (phase_q == PH_ASSERT);
   assign srst_o      = srst_q;
   assign acked_o     = acked_q;

endmodule

// File: rtl/srst_hs_status.sv
module srst_hs_status
   import srst_hs_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  srst_phase_e        phase_i,
   input  logic               srst_i,
   input  logic               acked_i,
   output logic [DATA_W-1:0]  status_o
);

   logic [STS_MIN_W-1:0] core;

   always_comb begin
      core = '0;
      core[STS_ACKED_BIT] = acked_i & srst_i;
      core[STS_SRST_BIT]  = srst_i;
      core[STS_PH_LSB +: STS_PH_W] = phase_i;
   end

   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
      if (gi < STS_MIN_W) begin : g_fld
         assign status_o[gi] = core[gi];
      end else begin : g_pad
         assign status_o[gi] = 1'b0;
      end
   end

endmodule

// File: rtl/srst_handshake.sv
module srst_handshake
   import srst_hs_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned HOLD_CYC = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              eng_ack,
   output logic              abort_req_o,
   output logic              srst_o,
   output logic [DATA_W-1:0] status_o
);

   if (DATA_W < STS_MIN_W) begin : g_bad_width
      $error("srst_handshake: DATA_W must be at least %0d", STS_MIN_W);
   end
   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("srst_handshake: HOLD_CYC must be at least 1");
   end

   srst_phase_e phase;
   logic        hold_load, hold_done, acked;
   logic        abort_wr, force_wr;

   assign abort_wr = wr_en & wr_data[CTL_ABORT_BIT];
   assign force_wr = wr_en & wr_data[CTL_FORCE_BIT];

   srst_hs_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .abort_wr_i  (abort_wr),
      .force_wr_i  (force_wr),
      .eng_ack_i   (eng_ack),
      .hold_done_i (hold_done),
      .phase_o     (phase),
      .hold_load_o (hold_load),
      .srst_o      (srst_o),
      .acked_o     (acked)
   );

   srst_hs_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (hold_load),
      .done_o (hold_done)
   );

   srst_hs_status #(.DATA_W(DATA_W)) u_status (
      .phase_i  (phase),
      .srst_i   (srst_o),
      .acked_i  (acked),
      .status_o (status_o)
   );

   assign abort_req_o = (phase == PH_REQ);

endmodule

// File: rtl/srst_handshake_chk.sv
module srst_handshake_chk #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned HOLD_CYC = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic              eng_ack,
   input logic              abort_req_o,
   input logic              srst_o,
   input logic [DATA_W-1:0] status_o
);

   localparam int unsigned CW = $clog2(HOLD_CYC + 1);

   logic [2:0]    ph;
   logic [CW-1:0] set_cnt;

   assign ph = status_o[6:4];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) set_cnt <= '0;
      else if (ph == 3'd4) set_cnt <= set_cnt + 1'b1;
      else set_cnt <= '0;
   end

   assert_req_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
      abort_req_o == (ph == 3'd1));

   assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == 3'd0 && wr_en && wr_data[0]) |=> (ph == 3'd1));

   assert_ignore_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == 3'd1 && wr_en && wr_data[0] && !wr_data[2] && !eng_ack) |=> (ph == 3'd1));

   assert_ack_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == 3'd1 && eng_ack && !(wr_en && wr_data[2])) |=> (ph == 3'd2));

   assert_acked_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == 3'd2) |=> (ph == 3'd3));

   assert_force_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == 3'd1 && wr_en && wr_data[2]) |=> (ph == 3'd3 && !status_o[1]));

   assert_srst_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
      srst_o == (ph == 3'd3 || ph == 3'd4));

   assert_acked_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[1] |-> srst_o);

   assert_hold_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == 3'd4) |-> (set_cnt < CW'(HOLD_CYC)));

   assert_hold_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == 3'd4 && set_cnt == CW'(HOLD_CYC - 1)) |=> (ph == 3'd0 && !srst_o));

   assert_zero_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !status_o[0] && !status_o[2] && ph <= 3'd4);

endmodule

bind srst_handshake srst_handshake_chk #(.DATA_W(DATA_W), .HOLD_CYC(HOLD_CYC)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_data     (wr_data),
   .eng_ack     (eng_ack),
   .abort_req_o (abort_req_o),
   .srst_o      (srst_o),
   .status_o    (status_o)
);

// File: tb/srst_handshake_tb.sv
`timescale 1ns/1ps
module srst_handshake_tb;

   localparam int unsigned DATA_W   = 32;
   localparam int unsigned HOLD_CYC = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              eng_ack = 1'b0;
   logic              abort_req_o, srst_o;
   logic [DATA_W-1:0] status_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int m_ph = 0;
   int m_cnt = 0;
   bit m_acked = 1'b0;

   always #4 clk = ~clk;

   srst_handshake #(.DATA_W(DATA_W), .HOLD_CYC(HOLD_CYC)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .eng_ack(eng_ack), .abort_req_o(abort_req_o), .srst_o(srst_o),
      .status_o(status_o)
   );

   task automatic check(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit m_srst();
      return (m_ph == 3 || m_ph == 4);
   endfunction

   function automatic logic [DATA_W-1:0] m_status();
      logic [DATA_W-1:0] s = '0;
      s[6:4] = 3'(m_ph);
      s[3]   = m_srst();
      s[1]   = m_acked & m_srst();
      return s;
   endfunction

   task automatic model_step(input bit we, input logic [DATA_W-1:0] d, input bit ack);
      case (m_ph)
         0: if (we && d[0]) begin m_ph = 1; m_acked = 1'b0; end
         1: if (we && d[2]) m_ph = 3;
            else if (ack) begin m_ph = 2; m_acked = 1'b1; end
         2: m_ph = 3;
         3: begin m_ph = 4; m_cnt = HOLD_CYC; end
         default: begin
            m_cnt--;
            if (m_cnt == 0) begin m_ph = 0; m_acked = 1'b0; end
         end
      endcase
   endtask

   task automatic compare_all();
      logic [DATA_W-1:0] e = m_status();
      check("R4 phase", status_o[6:4], e[6:4]);
      check("R6 srst", srst_o, m_srst());
      check("R6 status bit3", status_o[3], srst_o);
      check("R7 acked bit", status_o[1], e[1]);
      check("R2 abort_req", abort_req_o, (m_ph == 1));
      check("R9 zero bits", {status_o[DATA_W-1:7], status_o[2], status_o[0]}, 0);
   endtask

   task automatic cyc(input bit we, input logic [DATA_W-1:0] d, input bit ack);
      wr_en = we; wr_data = d; eng_ack = ack;
      @(posedge clk);
      model_step(we, d, ack);
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0; eng_ack = 1'b0;
      compare_all();
   endtask

   task automatic drain();
      for (int i = 0; i < 40 && m_ph != 0; i++) cyc(0, '0, 0);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed = 32'h5EED_1234;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 status", status_o, 0);
      check("R1 srst", srst_o, 0);
      check("R1 abort_req", abort_req_o, 0);

      // Acknowledge path, R2 R4 R7 R8
      cyc(1, 32'h1, 0);
      check("R2 phase requested", status_o[6:4], 1);
      // R3 repeated request while busy
      cyc(1, 32'h1, 0);
      check("R3 phase unchanged", status_o[6:4], 1);
      cyc(0, '0, 1);
      check("R4 acked phase", status_o[6:4], 2);
      cyc(0, '0, 0);
      cyc(0, '0, 0);
      check("R7 acked flag set", status_o[1], 1);
      begin
         int set_cycles = 1;
         cyc(1, 32'h1, 0); // R3 request during set phase
         if (status_o[6:4] == 4) set_cycles++;
         check("R3 ignored in set", status_o[6:4], (HOLD_CYC > 1) ? 4 : 0);
         while (status_o[6:4] == 4 && set_cycles < 100) begin
            cyc(0, '0, 0);
            if (status_o[6:4] == 4) set_cycles++;
         end
         check("R8 set length", set_cycles, HOLD_CYC);
         check("R8 released", srst_o, 0);
      end

      // R5 force in idle ignored
      cyc(1, 32'h4, 0);
      check("R5 force idle ignored", status_o[6:4], 0);
      // R5 force beats simultaneous ack
      cyc(1, 32'h1, 0);
      cyc(1, 32'h4, 1);
      check("R5 force to assert", status_o[6:4], 3);
      check("R7 forced flag clear", status_o[1], 0);
      drain();

      // random traffic
      for (int i = 0; i < 4000; i++) begin
         bit we = ($urandom % 3) == 0;
         logic [DATA_W-1:0] d = $urandom;
         bit ack = ($urandom % 4) == 0;
         cyc(we, d, ack);
      end
      drain();

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule